// File: doc/BRIEF.md
# Powered-Device Discovery Control and Status Register Bank

This block holds the management-visible control and status bits for a powered-device discovery function in a multi-port Ethernet PHY. Each port has its own four-bit slice. The slice contains a sticky enable bit, a read-only bit that asks for power, a clear-on-read flag that reports an ordinary link partner, and a clear-on-read flag for link-fail timeout. A management agent reaches the bank through a simple strobe-based read/write port. The agent selects a port by number, and read data comes back combinationally in the same cycle as the read strobe.

The slice does not move on its own. It follows per-port event strobes and levels from the rest of the PHY: a port soft reset, an auto-negotiation restart, the auto-negotiation disabled level, the link-up level, negotiation completing with a partner that already has power, detection of an ordinary partner, a possible powered device being found, and expiry of the link-fail timer. From the enable bit and the link state the block also decides, per port, whether discovery may run at that moment. It drives that decision out as a discovery-active output. Serial management framing, the analog detection and the power-supply switching all sit outside.

Top module: `pdd_csr_bank`

## Requirements
- R1: Under the synchronous reset `rst`, every field of every port reads 0 and every `disc_active` bit is 0.
- R2: Bit 0 of a port's register is the discovery enable. A write to that port loads it from `mgmt_wdata[0]`. Besides that write, only the port's `port_reset` changes it (to 0). It stays 1 across failed discovery attempts.
- R3: `disc_active[p]` is 1 exactly when the enable of port p is 1, `link_up[p]` is 0 and `an_disabled[p]` is 0. An enable written while link is up therefore has no effect until link drops.
- R4: Bit 1 is the read-only power-request bit. It sets when `pd_found[p]` arrives while discovery is active. It clears on `port_reset`, `an_restart`, `an_disabled` or `an_complete`, and these clears take priority over a set.
- R5: Bit 2 is the ordinary-partner flag. It sets when `std_partner_seen[p]` arrives while discovery is active. It clears on a read of its port, while the enable is 0, while link is up, on `an_restart`, while `an_disabled` is high, and on `port_reset`. Every clear except the read takes priority over a set.
- R6: Bit 3 is the link-fail-timeout flag. It sets when `lfit_expired[p]` arrives while discovery is active, and clears on a read of its port or on `port_reset`. It reads as 1 only while bit 2 is also 1.
- R7: When a read of a port and a set event for one of its clear-on-read flags fall in the same cycle, the read returns the old value and the flag is 1 afterwards.
- R8: Reads and writes affect only the port selected by `mgmt_port`. Reading one port leaves the flags of every other port untouched.
- R9: Bits above bit 3 always read 0. Writes to bits 1 to 3, or to any higher bit, have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of the whole bank |
| mgmt_port | input | PW | Port number selected by the management access |
| mgmt_wr | input | 1 | Write strobe |
| mgmt_rd | input | 1 | Read strobe; clears the selected port's clear-on-read flags |
| mgmt_wdata | input | DW | Write data |
| mgmt_rdata | output | DW | Register content of the selected port, combinational |
| port_reset | input | NPORTS | Per-port soft reset strobe |
| an_restart | input | NPORTS | Auto-negotiation restart strobe |
| an_disabled | input | NPORTS | Auto-negotiation disabled level |
| link_up | input | NPORTS | Link established level |
| an_complete | input | NPORTS | Partner already powered: negotiation completed or parallel detect |
| std_partner_seen | input | NPORTS | Ordinary partner signalling seen (normal link pulses, MLT-3 data, fast link pulses without a matching next page) |
| pd_found | input | NPORTS | Discovery found a device that probably needs power |
| lfit_expired | input | NPORTS | Link-fail timer expired |
| disc_active | output | NPORTS | Discovery may run on this port now |

## Verification
The assertions assume that the event inputs are sampled cleanly on the clock edge. They also assume that `mgmt_port` holds a valid port number whenever a strobe is high, and they make no assumption about how events relate to each other. The stimulus keeps to these assumptions by changing every input only at the falling edge. It draws port numbers only within range. It lets events of every kind coincide freely, including a read together with a set, so that each priority rule actually fires. The link and negotiation-disabled levels toggle slowly, so both held-off and active periods occur on every port.

// File: rtl/pdd_pkg.sv
`timescale 1ns/1ps
package pdd_pkg;

    // field positions inside a port's register
    localparam int FLD_EN   = 0;
    localparam int FLD_PWR  = 1;
    localparam int FLD_STD  = 2;
    localparam int FLD_LFIT = 3;
    localparam int FLD_W    = 4;

    typedef struct packed {
        logic lfit;
        logic std;
        logic pwr;
        logic en;
    } pdd_state_t;

    typedef struct packed {
        logic port_rst;
        logic an_restart;
        logic an_disabled;
        logic link_up;
        logic an_complete;
        logic std_seen;
        logic pd_found;
        logic lfit_exp;
    } pdd_evt_t;

    function automatic logic [FLD_W-1:0] pdd_pack(pdd_state_t s);
        logic [FLD_W-1:0] r;
        r            = '0;
        r[FLD_EN]    = s.en;
        r[FLD_PWR]   = s.pwr;
        r[FLD_STD]   = s.std;
        r[FLD_LFIT]  = s.lfit & s.std;
        return r;
    endfunction

endpackage

// File: rtl/pdd_port_slice.sv
`timescale 1ns/1ps
module pdd_port_slice
    import pdd_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_hit,
    input  logic       wr_bit,
    input  logic       rd_hit,
    input  pdd_evt_t   evt,
    output pdd_state_t state,
    output logic       active
);

    pdd_state_t nxt;
    logic       pwr_clr;
    logic       std_clr;

    assign active  = state.en & ~evt.link_up & ~evt.an_disabled;

    assign pwr_clr = evt.port_rst | evt.an_restart | evt.an_disabled | evt.an_complete;
    assign std_clr = evt.port_rst | ~state.en | evt.link_up | evt.an_restart | evt.an_disabled;

    always_comb begin
        nxt = state;

        if (evt.port_rst)     nxt.en = 1'b0;
        else if (wr_hit)      nxt.en = wr_bit;

        if (pwr_clr)                          nxt.pwr = 1'b0;
        else if (evt.pd_found && active)      nxt.pwr = 1'b1;

        if (std_clr)                          nxt.std = 1'b0;
        else if (evt.std_seen && active)      nxt.std = 1'b1;
        else if (rd_hit)                      nxt.std = 1'b0;

        if (evt.port_rst)                     nxt.lfit = 1'b0;
        else if (evt.lfit_exp && active)      nxt.lfit = 1'b1;
        else if (rd_hit)                      nxt.lfit = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) state <= '0;
        else     state <= nxt;
    end

endmodule

// File: rtl/pdd_rd_mux.sv
`timescale 1ns/1ps
module pdd_rd_mux
    import pdd_pkg::*;
#(
    parameter int NPORTS = 8,
    parameter int DW     = 16,
    localparam int PW    = (NPORTS > 1) ? $clog2(NPORTS) : 1
) (
    input  pdd_state_t [NPORTS-1:0] states,
    input  logic [PW-1:0]           sel,
    output logic [DW-1:0]           rdata
);

    always_comb begin
        rdata = '0;
        for (int i = 0; i < NPORTS; i++) begin
            if (sel == PW'(i)) rdata = DW'(pdd_pack(states[i]));
        end
    end

endmodule

// File: rtl/pdd_csr_bank.sv
`timescale 1ns/1ps
module pdd_csr_bank
    import pdd_pkg::*;
#(
    parameter int NPORTS = 8,
    parameter int DW     = 16,
    localparam int PW    = (NPORTS > 1) ? $clog2(NPORTS) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [PW-1:0]     mgmt_port,
    input  logic              mgmt_wr,
    input  logic              mgmt_rd,
    input  logic [DW-1:0]     mgmt_wdata,
    output logic [DW-1:0]     mgmt_rdata,
    input  logic [NPORTS-1:0] port_reset,
    input  logic [NPORTS-1:0] an_restart,
    input  logic [NPORTS-1:0] an_disabled,
    input  logic [NPORTS-1:0] link_up,
    input  logic [NPORTS-1:0] an_complete,
    input  logic [NPORTS-1:0] std_partner_seen,
    input  logic [NPORTS-1:0] pd_found,
    input  logic [NPORTS-1:0] lfit_expired,
    output logic [NPORTS-1:0] disc_active
);

    pdd_state_t [NPORTS-1:0] port_state;

    for (genvar g = 0; g < NPORTS; g++) begin : g_port
        pdd_evt_t ev;
        logic     sel_hit;

        assign sel_hit        = (mgmt_port == PW'(g));
        assign ev.port_rst    = port_reset[g];
        assign ev.an_restart  = an_restart[g];
        assign ev.an_disabled = an_disabled[g];
        assign ev.link_up     = link_up[g];
        assign ev.an_complete = an_complete[g];
        assign ev.std_seen    = std_partner_seen[g];
        assign ev.pd_found    = pd_found[g];
        assign ev.lfit_exp    = lfit_expired[g];

        pdd_port_slice u_slice (
            .clk    (clk),
            .rst    (rst),
            .wr_hit (mgmt_wr & sel_hit),
            .wr_bit (mgmt_wdata[FLD_EN]),
            .rd_hit (mgmt_rd & sel_hit),
            .evt    (ev),
            .state  (port_state[g]),
            .active (disc_active[g])
        );
    end

    pdd_rd_mux #(.NPORTS(NPORTS), .DW(DW)) u_mux (
        .states (port_state),
        .sel    (mgmt_port),
        .rdata  (mgmt_rdata)
    );

endmodule

// File: rtl/pdd_csr_checker.sv
`timescale 1ns/1ps
module pdd_csr_checker
    import pdd_pkg::*;
#(
    parameter int NPORTS = 8,
    parameter int DW     = 16,
    localparam int PW    = (NPORTS > 1) ? $clog2(NPORTS) : 1
) (
    input logic                    clk,
    input logic                    rst,
    input logic [PW-1:0]           mgmt_port,
    input logic                    mgmt_wr,
    input logic [DW-1:0]           mgmt_rdata,
    input logic [NPORTS-1:0]       port_reset,
    input logic [NPORTS-1:0]       an_restart,
    input logic [NPORTS-1:0]       an_disabled,
    input logic [NPORTS-1:0]       link_up,
    input logic [NPORTS-1:0]       an_complete,
    input logic [NPORTS-1:0]       std_partner_seen,
    input logic [NPORTS-1:0]       disc_active,
    input pdd_state_t [NPORTS-1:0] port_state
);

    assert_upper_zero_R9: assert property (@(posedge clk) disable iff (rst)
        mgmt_rdata[DW-1:FLD_W] == '0);

    assert_lfit_masked_R6: assert property (@(posedge clk) disable iff (rst)
        mgmt_rdata[FLD_LFIT] |-> mgmt_rdata[FLD_STD]);

    for (genvar i = 0; i < NPORTS; i++) begin : g_chk
        assert_enable_sticky_R2: assert property (@(posedge clk) disable iff (rst)
            (!port_reset[i] && !(mgmt_wr && mgmt_port == PW'(i)))
            |=> $stable(port_state[i].en));

        assert_link_holds_off_R3: assert property (@(posedge clk) disable iff (rst)
            (link_up[i] || an_disabled[i]) |-> !disc_active[i]);

        assert_pwr_cleared_R4: assert property (@(posedge clk) disable iff (rst)
            (an_restart[i] || an_disabled[i] || an_complete[i] || port_reset[i])
            |=> !port_state[i].pwr);

        assert_std_cleared_R5: assert property (@(posedge clk) disable iff (rst)
            (link_up[i] || an_restart[i] || port_reset[i]) |=> !port_state[i].std);

        assert_set_beats_read_R7: assert property (@(posedge clk) disable iff (rst)
            (std_partner_seen[i] && disc_active[i] && !an_restart[i] && !port_reset[i])
            |=> port_state[i].std);
    end

endmodule

bind pdd_csr_bank pdd_csr_checker #(.NPORTS(NPORTS), .DW(DW)) u_chk (
    .clk              (clk),
    .rst              (rst),
    .mgmt_port        (mgmt_port),
    .mgmt_wr          (mgmt_wr),
    .mgmt_rdata       (mgmt_rdata),
    .port_reset       (port_reset),
    .an_restart       (an_restart),
    .an_disabled      (an_disabled),
    .link_up          (link_up),
    .an_complete      (an_complete),
    .std_partner_seen (std_partner_seen),
    .disc_active      (disc_active),
    .port_state       (port_state)
);

// File: tb/pdd_csr_bank_test.sv
`timescale 1ns/1ps
module pdd_csr_bank_test;

    localparam int N  = 8;
    localparam int DW = 16;
    localparam int PW = 3;

    logic          clk = 1'b0;
    logic          rst;
    logic [PW-1:0] mport;
    logic          mwr, mrd;
    logic [DW-1:0] mwdata, mrdata;
    logic [N-1:0]  prst, anr, andis, lup, ancmp, stdv, pdf, lfx, dact;

    int total = 0;
    int bad   = 0;
    int m_en[N], m_pw[N], m_sp[N], m_lf[N];

    always #10 clk = ~clk;

    pdd_csr_bank #(.NPORTS(N), .DW(DW)) uut (
        .clk(clk), .rst(rst), .mgmt_port(mport), .mgmt_wr(mwr), .mgmt_rd(mrd),
        .mgmt_wdata(mwdata), .mgmt_rdata(mrdata), .port_reset(prst),
        .an_restart(anr), .an_disabled(andis), .link_up(lup), .an_complete(ancmp),
        .std_partner_seen(stdv), .pd_found(pdf), .lfit_expired(lfx),
        .disc_active(dact)
    );

    task automatic chk(string tag, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // compare outputs with the behavioural model every cycle
    task automatic compare();
        int s;
        s = int'(mport);
        for (int p = 0; p < N; p++)
            chk("R3 disc_active", int'(dact[p]),
                (m_en[p] != 0 && !lup[p] && !andis[p]) ? 1 : 0);
        chk("R2 enable field", int'(mrdata[0]), m_en[s]);
        chk("R4 power field", int'(mrdata[1]), m_pw[s]);
        chk("R5 partner field", int'(mrdata[2]), m_sp[s]);
        chk("R6 timeout field", int'(mrdata[3]), (m_lf[s] != 0 && m_sp[s] != 0) ? 1 : 0);
        chk("R9 upper bits", int'(mrdata[DW-1:4]), 0);
    endtask

    task automatic model_update();
        for (int p = 0; p < N; p++) begin
            int act, rdh, wrh;
            if (rst) begin
                m_en[p] = 0; m_pw[p] = 0; m_sp[p] = 0; m_lf[p] = 0;
            end else begin
                act = (m_en[p] != 0 && !lup[p] && !andis[p]) ? 1 : 0;
                rdh = (mrd && int'(mport) == p) ? 1 : 0;
                wrh = (mwr && int'(mport) == p) ? 1 : 0;
                // R5 clears use the enable before this edge
                if (prst[p] || m_en[p] == 0 || lup[p] || anr[p] || andis[p]) m_sp[p] = 0;
                else if (stdv[p] && act != 0) m_sp[p] = 1;
                else if (rdh != 0) m_sp[p] = 0;
                if (prst[p]) m_lf[p] = 0;
                else if (lfx[p] && act != 0) m_lf[p] = 1;
                else if (rdh != 0) m_lf[p] = 0;
                if (prst[p] || anr[p] || andis[p] || ancmp[p]) m_pw[p] = 0;
                else if (pdf[p] && act != 0) m_pw[p] = 1;
                if (prst[p]) m_en[p] = 0;
                else if (wrh != 0) m_en[p] = int'(mwdata[0]);
            end
        end
    endtask

    task automatic cyc();
        #1;
        if (!rst) compare();
        model_update();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic clr();
        prst = '0; anr = '0; ancmp = '0; stdv = '0; pdf = '0; lfx = '0;
        mwr = 1'b0; mrd = 1'b0;
    endtask

    task automatic wr(int port, logic [DW-1:0] val);
        mport = PW'(port); mwdata = val; mwr = 1'b1;
        cyc();
        clr();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst = 1'b1; andis = '0; lup = '0; mport = '0; mwdata = '0;
        clr();
        @(negedge clk);
        repeat (3) cyc();
        rst = 1'b0;
        #1;
        chk("R1 reset rdata", int'(mrdata), 0);
        chk("R1 reset disc_active", int'(dact), 0);

        // R3: enable while link up is held off
        lup[0] = 1'b1;
        wr(0, 16'h0001);
        #1 chk("R3 held while link up", int'(dact[0]), 0);
        lup[0] = 1'b0;
        cyc();
        #1 chk("R3 runs after link drop", int'(dact[0]), 1);

        // R4 set and clear by already-powered partner
        pdf[0] = 1'b1; cyc(); clr();
        mport = 0;
        #1 chk("R4 power set", int'(mrdata[1]), 1);
        ancmp[0] = 1'b1; cyc(); clr();
        #1 chk("R4 cleared by powered partner", int'(mrdata[1]), 0);

        // R5/R6 set
        stdv[0] = 1'b1; lfx[0] = 1'b1; cyc(); clr();
        #1 chk("R6 both flags", int'(mrdata[3:2]), 3);

        // R7 read coinciding with new partner event
        mrd = 1'b1; stdv[0] = 1'b1; cyc(); clr();
        #1 chk("R7 set wins over read", int'(mrdata[2]), 1);
        chk("R6 timeout cleared by read", int'(mrdata[3]), 0);

        // R8 reading port 0 leaves port 1 alone
        wr(1, 16'h0001);
        stdv[1] = 1'b1; cyc(); clr();
        mport = 0; mrd = 1'b1; cyc(); clr();
        mport = 1;
        #1 chk("R8 other port kept", int'(mrdata[2]), 1);

        // R5 cleared once enable is 0
        wr(1, 16'h0000);
        cyc();
        #1 chk("R5 cleared by disable", int'(mrdata), 0);

        // R9 only enable is writable
        wr(2, 16'hFFFF);
        #1 chk("R9 write only enable", int'(mrdata), 1);
        prst[2] = 1'b1; cyc(); clr();
        #1 chk("R2 port reset clears enable", int'(mrdata), 0);
        mport = 0;
        #1 chk("R2 enable sticky", int'(mrdata[0]), 1);

        // mixed stimulus against the model
        for (int n = 0; n < 3000; n++) begin
            for (int p = 0; p < N; p++) begin
                prst[p]  = ($urandom % 97) == 0;
                anr[p]   = ($urandom % 41) == 0;
                ancmp[p] = ($urandom % 29) == 0;
                stdv[p]  = ($urandom % 7) == 0;
                pdf[p]   = ($urandom % 9) == 0;
                lfx[p]   = ($urandom % 11) == 0;
                if (($urandom % 37) == 0) andis[p] = ~andis[p];
                if (($urandom % 23) == 0) lup[p] = ~lup[p];
            end
            mport  = PW'($urandom % N);
            mwr    = ($urandom % 6) == 0;
            mrd    = ($urandom % 4) == 0;
            mwdata = DW'($urandom);
            cyc();
        end
        clr();
        cyc();

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule